// File: doc/BRIEF.md
# Token-Passing Node Transmit Sequencer

This block runs the transmit side of a node on a token-passing network. A host first puts a packet into one of several buffer pages. It then issues an enable-transmit command that carries the page number and a broadcast flag. From then on the sequencer waits for the token. On each token arrival it either asks the destination whether a free buffer exists, or sends the packet directly when the packet is a broadcast. It reacts to the reply and finally reports the outcome through two status bits. The transmit-available bit (`ta`) means the sequencer is ready for a new command. The transmit-acknowledged bit (`tma`) means the last packet was acknowledged by its receiver.

The line coding, the frame serializer, the reply decoder and the network reconfiguration logic live outside this block. Their events arrive as single-cycle strobes. The sequencer issues its own actions as single-cycle request pulses: send the enquiry, send the packet, or pass the token on.

Other behaviour:
- Consecutive negative replies to the enquiry are counted. Once the count reaches a threshold, a sticky excessive-NAK flag is set.
- A host cancel request is held until the next token arrival, and takes effect there.
- The interrupt line combines the two status events with their mask inputs.

Top module: `tkn_tx_seq`

## Requirements
- R1: After synchronous reset, `ta`=1, `tma`=0, `exnak`=0, `cur_page`=0, and no request pulse is asserted.
- R2: `cmd_tx_en` is accepted only while `ta`=1. Acceptance clears `ta` and `tma` on the next cycle and latches `cmd_tx_page` into `cur_page`. A command given while `ta`=0 leaves `cur_page`, `ta` and `tma` unchanged.
- R3: For a pending non-broadcast packet, a `token_in` strobe produces a one-cycle `req_fbe` pulse on the following cycle.
- R4: Suppose the enquiry gets an ACK reply (`rsp_code`=2'b01). Then `req_pkt` pulses on the next cycle. After `send_done`, an ACK reply to the packet sets `ta`=1 and `tma`=1 and pulses `req_pass`.
- R5: If the reply to a sent packet is anything but ACK, `ta` becomes 1 and `tma` stays 0, and `req_pass` pulses.
- R6: A NAK reply to the enquiry (`rsp_code`=2'b10) pulses `req_pass`, keeps the transmission pending, and the next `token_in` again produces `req_fbe`.
- R7: `exnak` becomes 1 on the 128th consecutive enquiry NAK and stays set until the next accepted command. The consecutive-NAK count restarts on any ACK reply and on every accepted command.
- R8: A silent reply to the enquiry (`rsp_code`=2'b00) sets `ta`=1, leaves `tma`=0 and pulses `req_pass`. A later `token_in` produces no request.
- R9: A corrupt reply to the enquiry (`rsp_code`=2'b11) produces no `req_pass` and keeps the transmission pending. The next `token_in` produces `req_fbe` again.
- R10: `cmd_tx_off` while a transmission is pending takes effect at the next `token_in`. On the following cycle `ta`=1, `tma`=0, `req_pass` pulses, and neither `req_fbe` nor `req_pkt` pulses.
- R11: For a broadcast packet (`cmd_tx_bcast`=1), `token_in` produces `req_pkt` directly with no `req_fbe`. `send_done` then sets `ta`=1 with `tma`=0 and pulses `req_pass`.
- R12: `irq` equals (`ta` AND `mask_ta`) OR (`exnak` AND `mask_exnak`) at all times.
- R13: At most one of `req_fbe`, `req_pkt` and `req_pass` is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_tx_en | input | 1 | Enable-transmit command strobe |
| cmd_tx_page | input | PAGE_W | Buffer page named by the command |
| cmd_tx_bcast | input | 1 | Command is a broadcast |
| cmd_tx_off | input | 1 | Cancel (disable transmitter) command strobe |
| token_in | input | 1 | Token arrived at this node |
| rsp_valid | input | 1 | Reply decoder has a result |
| rsp_code | input | 2 | 00 silent, 01 ACK, 10 NAK, 11 corrupt |
| send_done | input | 1 | Serializer finished sending the packet |
| mask_ta | input | 1 | Interrupt mask for transmit-available |
| mask_exnak | input | 1 | Interrupt mask for excessive NAK |
| req_fbe | output | 1 | Pulse: send free-buffer enquiry |
| req_pkt | output | 1 | Pulse: send the packet from `cur_page` |
| req_pass | output | 1 | Pulse: pass the token on |
| cur_page | output | PAGE_W | Latched buffer page |
| ta | output | 1 | Transmit available |
| tma | output | 1 | Transmit acknowledged |
| exnak | output | 1 | Excessive-NAK diagnostic flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume well-behaved surrounding logic:
- Every strobe input is a single-cycle pulse.
- `rsp_valid` is raised only when a reply or a reply timeout is due, that is, after an enquiry or after `send_done`.
- `send_done` comes only after a `req_pkt`.

The stimulus never raises these strobes outside those windows. It also never presents `token_in` in the same cycle as `cmd_tx_off` or `cmd_tx_en`, so the one-token deferral of a cancel is always measured from a clean edge. Mask inputs change only between scenarios, so the interrupt comparison sees a settled level.

// File: rtl/tkn_tx_pkg.sv
package tkn_tx_pkg;

    typedef enum logic [1:0] {
        RSP_SILENT = 2'b00,
        RSP_ACK    = 2'b01,
        RSP_NAK    = 2'b10,
        RSP_OTHER  = 2'b11
    } rsp_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_TOK,
        ST_FBE_WAIT,
        ST_PKT_SEND,
        ST_PKT_WAIT
    } seq_st_e;

    typedef struct packed {
        logic fbe;
        logic pkt;
        logic pass;
    } req_t;

    typedef struct packed {
        logic fire;
        logic ok;
    } done_t;

    function automatic rsp_e decode_rsp(input logic [1:0] code);
        return rsp_e'(code);
    endfunction

    function automatic done_t finish(input logic ok);
        done_t d;
        d.fire = 1'b1;
        d.ok   = ok;
        return d;
    endfunction

endpackage

// File: rtl/tkn_nak_cnt.sv
module tkn_nak_cnt #(
    parameter int NAK_LIMIT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic clr_cnt,
    input  logic clr_flag,
    output logic flag
);
    localparam int CW = $clog2(NAK_LIMIT + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;

    assign cnt_nx = cnt + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            if (clr_cnt) begin
                cnt <= '0;
            end else if (inc && cnt != CW'(NAK_LIMIT)) begin
                cnt <= cnt_nx;
                if (cnt_nx == CW'(NAK_LIMIT)) flag <= 1'b1;
            end
            if (clr_flag) flag <= 1'b0;
        end
    end

    // R7
    exnak_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> (cnt == CW'(NAK_LIMIT)));

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(NAK_LIMIT));

endmodule

// File: rtl/tkn_tx_status.sv
module tkn_tx_status
    import tkn_tx_pkg::*;
#(
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              bcast_in,
    input  done_t             done,
    input  logic              exnak,
    input  logic              mask_ta,
    input  logic              mask_exnak,
    output logic [PAGE_W-1:0] page,
    output logic              bcast,
    output logic              ta,
    output logic              tma,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ta    <= 1'b1;
            tma   <= 1'b0;
            page  <= '0;
            bcast <= 1'b0;
        end else if (accept) begin
            ta    <= 1'b0;
            tma   <= 1'b0;
            page  <= page_in;
            bcast <= bcast_in;
        end else if (done.fire) begin
            ta  <= 1'b1;
            tma <= done.ok;
        end
    end

    assign irq = (ta & mask_ta) | (exnak & mask_exnak);

    // R2
    ta_fall_clears_tma_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ta) |-> !tma);

    // R4
    tma_only_with_ta_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tma) |-> ta);

    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ta |=> $stable(page));

endmodule

// File: rtl/tkn_tx_seq.sv
module tkn_tx_seq
    import tkn_tx_pkg::*;
#(
    parameter int PAGE_W    = 2,
    parameter int NAK_LIMIT = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_tx_en,
    input  logic [PAGE_W-1:0] cmd_tx_page,
    input  logic              cmd_tx_bcast,
    input  logic              cmd_tx_off,
    input  logic              token_in,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_code,
    input  logic              send_done,
    input  logic              mask_ta,
    input  logic              mask_exnak,
    output logic              req_fbe,
    output logic              req_pkt,
    output logic              req_pass,
    output logic [PAGE_W-1:0] cur_page,
    output logic              ta,
    output logic              tma,
    output logic              exnak,
    output logic              irq
);
    seq_st_e st, st_n;
    req_t    req_q, req_n;
    done_t   done_n;
    logic    cancel, cancel_n;
    logic    bcast;
    logic    accept;
    logic    nak_inc, nak_clr;
    rsp_e    rsp;

    assign accept = cmd_tx_en && ta;
    assign rsp    = decode_rsp(rsp_code);

    always_comb begin
        st_n    = st;
        req_n   = '0;
        done_n  = '0;
        nak_inc = 1'b0;
        nak_clr = accept;
        case (st)
            ST_IDLE: begin
                if (accept) st_n = ST_WAIT_TOK;
            end
            ST_WAIT_TOK: begin
                if (token_in) begin
                    if (cancel) begin
                        req_n.pass = 1'b1;
                        done_n     = finish(1'b0);
                        st_n       = ST_IDLE;
                    end else if (bcast) begin
                        req_n.pkt = 1'b1;
                        st_n      = ST_PKT_SEND;
                    end else begin
                        req_n.fbe = 1'b1;
                        st_n      = ST_FBE_WAIT;
                    end
                end
            end
            ST_FBE_WAIT: begin
                if (rsp_valid) begin
                    case (rsp)
                        RSP_ACK: begin
                            req_n.pkt = 1'b1;
                            nak_clr   = 1'b1;
                            st_n      = ST_PKT_SEND;
                        end
                        RSP_NAK: begin
                            req_n.pass = 1'b1;
                            nak_inc    = 1'b1;
                            st_n       = ST_WAIT_TOK;
                        end
                        RSP_SILENT: begin
                            req_n.pass = 1'b1;
                            done_n     = finish(1'b0);
                            st_n       = ST_IDLE;
                        end
                        default: begin
                            st_n = ST_WAIT_TOK;
                        end
                    endcase
                end
            end
            ST_PKT_SEND: begin
                if (send_done) begin
                    if (bcast) begin
                        req_n.pass = 1'b1;
                        done_n     = finish(1'b0);
                        st_n       = ST_IDLE;
                    end else begin
                        st_n = ST_PKT_WAIT;
                    end
                end
            end
            ST_PKT_WAIT: begin
                if (rsp_valid) begin
                    req_n.pass = 1'b1;
                    done_n     = finish(rsp == RSP_ACK);
                    nak_clr    = (rsp == RSP_ACK);
                    st_n       = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase

        if (st_n == ST_IDLE || accept)
            cancel_n = 1'b0;
        else if (cmd_tx_off && st != ST_IDLE)
            cancel_n = 1'b1;
        else
            cancel_n = cancel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            req_q  <= '0;
            cancel <= 1'b0;
        end else begin
            st     <= st_n;
            req_q  <= req_n;
            cancel <= cancel_n;
        end
    end

    assign req_fbe  = req_q.fbe;
    assign req_pkt  = req_q.pkt;
    assign req_pass = req_q.pass;

    tkn_nak_cnt #(
        .NAK_LIMIT(NAK_LIMIT)
    ) u_nak (
        .clk     (clk),
        .rst     (rst),
        .inc     (nak_inc),
        .clr_cnt (nak_clr),
        .clr_flag(accept),
        .flag    (exnak)
    );

    tkn_tx_status #(
        .PAGE_W(PAGE_W)
    ) u_stat (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .page_in   (cmd_tx_page),
        .bcast_in  (cmd_tx_bcast),
        .done      (done_n),
        .exnak     (exnak),
        .mask_ta   (mask_ta),
        .mask_exnak(mask_exnak),
        .page      (cur_page),
        .bcast     (bcast),
        .ta        (ta),
        .tma       (tma),
        .irq       (irq)
    );

    // R13
    one_req_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_fbe, req_pkt, req_pass}));

    // R3
    fbe_on_token_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT_TOK && token_in && !cancel && !bcast) |=> req_fbe);

    // R10
    cancel_at_token_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT_TOK && token_in && cancel) |=> (ta && !tma && req_pass));

    // R9
    corrupt_no_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FBE_WAIT && rsp_valid && rsp == RSP_OTHER) |=> (!req_pass && !ta));

    // R2
    idle_iff_ta_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) == ta);

endmodule

// File: tb/sim_tkn_tx_seq.sv
module sim_tkn_tx_seq;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, bc = 0, off = 0, tok = 0, rv = 0, sd = 0, mta = 0, mex = 0;
    logic [PW-1:0] pg = '0;
    logic [1:0] code = 2'b00;
    logic r_fbe, r_pkt, r_pass, o_ta, o_tma, o_ex, o_irq;
    logic [PW-1:0] o_pg;

    always #2 clk = ~clk;

    tkn_tx_seq #(.PAGE_W(PW), .NAK_LIMIT(128)) u0 (
        .clk(clk), .rst(rst), .cmd_tx_en(en), .cmd_tx_page(pg), .cmd_tx_bcast(bc),
        .cmd_tx_off(off), .token_in(tok), .rsp_valid(rv), .rsp_code(code),
        .send_done(sd), .mask_ta(mta), .mask_exnak(mex),
        .req_fbe(r_fbe), .req_pkt(r_pkt), .req_pass(r_pass), .cur_page(o_pg),
        .ta(o_ta), .tma(o_tma), .exnak(o_ex), .irq(o_irq));

    int tests = 0, fails = 0, cycles = 0;

    // behavioural reference: phase 0 ready, 1 holding for token,
    // 2 enquiry out, 3 packet going, 4 packet reply due
    int ph = 0, naks = 0;
    bit m_ta = 1, m_tma = 0, m_ex = 0, m_cancel = 0, m_bc = 0;
    bit m_fbe = 0, m_pkt = 0, m_pass = 0;
    int m_pg = 0;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            ph = 0; naks = 0; m_ta = 1; m_tma = 0; m_ex = 0; m_cancel = 0;
            m_bc = 0; m_pg = 0; m_fbe = 0; m_pkt = 0; m_pass = 0;
        end else begin
            m_fbe = 0; m_pkt = 0; m_pass = 0;
            if (ph == 0) begin
                if (en) begin
                    m_ta = 0; m_tma = 0; m_pg = int'(pg); m_bc = bc;
                    naks = 0; m_ex = 0; m_cancel = 0; ph = 1;
                end
            end else begin
                if (ph == 1 && tok) begin
                    if (m_cancel) begin m_pass = 1; m_ta = 1; ph = 0; end
                    else if (m_bc) begin m_pkt = 1; ph = 3; end
                    else begin m_fbe = 1; ph = 2; end
                end else if (ph == 2 && rv) begin
                    if (code == 2'b01) begin m_pkt = 1; naks = 0; ph = 3; end
                    else if (code == 2'b10) begin
                        m_pass = 1; if (naks < 128) naks++;
                        if (naks == 128) m_ex = 1;
                        ph = 1;
                    end else if (code == 2'b00) begin m_pass = 1; m_ta = 1; ph = 0; end
                    else ph = 1;
                end else if (ph == 3 && sd) begin
                    if (m_bc) begin m_pass = 1; m_ta = 1; ph = 0; end
                    else ph = 4;
                end else if (ph == 4 && rv) begin
                    m_pass = 1; m_ta = 1; m_tma = (code == 2'b01);
                    if (code == 2'b01) naks = 0;
                    ph = 0;
                end
                if (ph == 0) m_cancel = 0;
                else if (off) m_cancel = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk(o_ta == m_ta, "R2 ta", o_ta, m_ta);
            chk(o_tma == m_tma, "R4 tma", o_tma, m_tma);
            chk(o_ex == m_ex, "R7 exnak", o_ex, m_ex);
            chk(r_fbe == m_fbe, "R3 req_fbe", r_fbe, m_fbe);
            chk(r_pkt == m_pkt, "R11 req_pkt", r_pkt, m_pkt);
            chk(r_pass == m_pass, "R6 req_pass", r_pass, m_pass);
            chk(int'(o_pg) == m_pg, "R2 cur_page", o_pg, m_pg);
            chk(o_irq == ((m_ta & mta) | (m_ex & mex)), "R12 irq", o_irq,
                (m_ta & mta) | (m_ex & mex));
            chk((r_fbe + r_pkt + r_pass) <= 1, "R13 requests", r_fbe + r_pkt + r_pass, 1);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        en = 0; off = 0; tok = 0; rv = 0; sd = 0;
    endtask

    task automatic cmd(input int page, input bit b);
        en = 1; pg = PW'(page); bc = b; tick();
    endtask

    task automatic token();
        tok = 1; tick();
    endtask

    task automatic reply(input logic [1:0] c);
        rv = 1; code = c; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        // R1
        chk(o_ta == 1 && o_tma == 0 && o_ex == 0, "R1 reset status", {o_ta, o_tma, o_ex}, 3'b100);
        chk(o_pg == 0 && !r_fbe && !r_pkt && !r_pass, "R1 reset requests", o_pg, 0);
        tick();

        // R4 full success
        mta = 1;
        cmd(1, 0);
        chk(o_ta == 0, "R2 accepted", o_ta, 0);
        cmd(3, 0);
        chk(o_pg == 1, "R2 ignored while busy", o_pg, 1);
        token();
        chk(r_fbe == 1, "R3 enquiry pulse", r_fbe, 1);
        tick();
        reply(2'b01);
        chk(r_pkt == 1, "R4 packet request", r_pkt, 1);
        sd = 1; tick();
        reply(2'b01);
        chk(o_ta == 1 && o_tma == 1 && r_pass, "R4 acked", {o_ta, o_tma}, 3);
        tick();

        // R5 packet with no reply
        cmd(2, 0); token(); reply(2'b01); sd = 1; tick(); tick();
        reply(2'b00);
        chk(o_ta == 1 && o_tma == 0, "R5 unacked", {o_ta, o_tma}, 2);
        tick();

        // R6 NAK then retry
        cmd(0, 0); token(); reply(2'b10);
        chk(r_pass == 1 && o_ta == 0, "R6 pass after NAK", r_pass, 1);
        tick(); token();
        chk(r_fbe == 1, "R6 enquiry again", r_fbe, 1);
        reply(2'b01); sd = 1; tick(); reply(2'b01); tick();

        // R8 silent enquiry
        cmd(1, 0); token(); reply(2'b00);
        chk(o_ta == 1 && o_tma == 0 && r_pass, "R8 silent", {o_ta, o_tma}, 2);
        token();
        chk(!r_fbe && !r_pkt && !r_pass, "R8 no retry", r_fbe, 0);

        // R9 corrupt reply
        cmd(2, 0); token(); reply(2'b11);
        chk(!r_pass && o_ta == 0, "R9 token held", r_pass, 0);
        tick(); token();
        chk(r_fbe == 1, "R9 enquiry again", r_fbe, 1);

        // R10 cancel deferred to token
        reply(2'b10); off = 1; tick();
        chk(o_ta == 0, "R10 deferred", o_ta, 0);
        token();
        chk(o_ta == 1 && o_tma == 0 && r_pass && !r_fbe, "R10 cancelled", {o_ta, o_tma}, 2);
        tick();

        // R11 broadcast
        cmd(3, 1); token();
        chk(r_pkt == 1 && r_fbe == 0, "R11 direct send", r_pkt, 1);
        sd = 1; tick();
        chk(o_ta == 1 && o_tma == 0 && r_pass, "R11 broadcast done", {o_ta, o_tma}, 2);
        tick();

        // R7 excessive NAK, count restart on ACK
        mex = 1; mta = 0;
        cmd(1, 0);
        for (int i = 0; i < 100; i++) begin token(); reply(2'b10); end
        token(); reply(2'b01); sd = 1; tick(); reply(2'b10); tick();
        cmd(2, 0);
        for (int i = 0; i < 127; i++) begin token(); reply(2'b10); end
        chk(o_ex == 0, "R7 below limit", o_ex, 0);
        token(); reply(2'b10);
        chk(o_ex == 1 && o_irq == 1, "R7 limit reached", o_ex, 1);
        off = 1; tick(); token();
        chk(o_ex == 1, "R7 sticky", o_ex, 1);
        cmd(0, 0);
        chk(o_ex == 0 && o_irq == 0, "R12 cleared by command", o_irq, 0);
        off = 1; tick(); token(); tick();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule